// File: doc/BRIEF.md
# Register Switching Activity Pattern Generator

This block drives three registered bit-vectors of a configurable width, each built so that exactly one measure of switching activity changes from cycle to cycle. It is meant to be placed on a die or a prototype to study how supply current depends on register data. The first vector, the walker, keeps one bit set and moves it. The second vector, the ramp, has a Hamming weight that climbs and falls. The third vector, the flipper, has a per-cycle toggle count that climbs and falls.

All three vectors follow one shared sweep position and one shared sweep direction. While enable is high the position moves by one each clock edge, from 0 up to WIDTH-1 and back down to 0. It turns at either end without pausing. The walker holds a one at the position. The ramp is a thermometer code with every bit below the position set. Each edge the flipper takes its old value XOR the ramp's old value, so its toggle count on an edge equals the position before that edge. While enable is low every register holds. A synchronous reset takes priority over enable.

Top module: `switch_activity_gen`

## Requirements
- R1: When `rst` is high at a rising edge, after that edge `walk_o` has only bit 0 set, `ramp_o` is all zeros and `flip_o` is all zeros, whatever the value of `en`.
- R2: At all times after reset, `walk_o` has exactly one bit set. The index of that bit is called the position.
- R3: On each rising edge with `en` high and `rst` low, the position rises by one in the rising direction and falls by one in the falling direction. Reset selects the rising direction.
- R4: At position WIDTH-1 the direction changes to falling and the next position is WIDTH-2. At position 0 in the falling direction it changes to rising and the next position is 1. The position never stays on an end for two edges.
- R5: `ramp_o` is a thermometer code: bits 0 to position-1 are one and all other bits are zero. Its Hamming weight therefore equals the position, from 0 to WIDTH-1.
- R6: On each enabled edge, `flip_o` becomes its previous value XOR the previous `ramp_o`. The number of bits that toggle equals the position before the edge.
- R7: On a rising edge with `en` low and `rst` low, `walk_o`, `ramp_o`, `flip_o` and the sweep direction all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, takes priority over `en` |
| en | input | 1 | Advances the sweep by one step per edge while high |
| walk_o | output | WIDTH | Single walking one; Hamming weight fixed at one |
| ramp_o | output | WIDTH | Thermometer code whose weight equals the position |
| flip_o | output | WIDTH | Vector whose per-edge toggle count equals the position |

## Verification
The assertions check, on every edge, the invariants that hold between the registers. These are: the walker stays one-hot; the ramp plus one equals the walker; the flipper's toggle count equals the previous ramp weight; everything holds while disabled; and the walker turns back at both ends. A wrong sequence could still satisfy all of these, so the bench's reference model is needed for the rest. It shows the actual order of positions over several full sweeps and pause patterns, that the flipper's absolute value is right after repeated sweeps, and that a reset in the middle of a sweep, with enable high or low, restores the start state.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic {SWEEP_UP = 1'b0, SWEEP_DOWN = 1'b1} sweep_dir_e;

  // Effective step direction for this edge: 1 means the position goes up.
  function automatic logic step_is_up(sweep_dir_e dir, logic at_top, logic at_bottom);
    if (dir == SWEEP_UP) return !at_top;
    else                 return at_bottom;
  endfunction
endpackage

// File: rtl/srg_sweep_ctrl.sv
module srg_sweep_ctrl
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       at_top,
  input  logic       at_bottom,
  output logic       step_up,
  output logic       turn_evt,
  output sweep_dir_e dir_q
);
  sweep_dir_e dir_d;

  assign step_up  = step_is_up(dir_q, at_top, at_bottom);
  assign dir_d    = step_up ? SWEEP_UP : SWEEP_DOWN;
  assign turn_evt = en && (dir_d != dir_q);

  always_ff @(posedge clk) begin
    if (rst)     dir_q <= SWEEP_UP;
    else if (en) dir_q <= dir_d;
  end

  // R4
  top_turn_chk: assert property (@(posedge clk) disable iff (rst)
    at_top |-> !step_up);
  // R4
  bottom_turn_chk: assert property (@(posedge clk) disable iff (rst)
    at_bottom |-> step_up);
  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dir_q));
endmodule

// File: rtl/srg_walk_reg.sv
module srg_walk_reg #(
  parameter int WIDTH = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step_up,
  output logic [WIDTH-1:0] walk_q,
  output logic             at_top,
  output logic             at_bottom
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] move_one(logic [WIDTH-1:0] v, logic up);
    return up ? (v << 1) : (v >> 1);
  endfunction

  assign at_top    = walk_q[MSB];
  assign at_bottom = walk_q[0];

  always_ff @(posedge clk) begin
    if (rst)     walk_q <= WIDTH'(1);
    else if (en) walk_q <= move_one(walk_q, step_up);
  end

  // R2
  one_hot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(walk_q));
endmodule

// File: rtl/srg_thermo_reg.sv
module srg_thermo_reg #(
  parameter int WIDTH = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step_up,
  output logic [WIDTH-1:0] ramp_q
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] thermo_step(logic [WIDTH-1:0] v, logic up);
    return up ? {v[MSB-1:0], 1'b1} : {1'b0, v[MSB:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     ramp_q <= '0;
    else if (en) ramp_q <= thermo_step(ramp_q, step_up);
  end
endmodule

// File: rtl/srg_toggle_reg.sv
module srg_toggle_reg #(
  parameter int WIDTH = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] toggle_mask,
  output logic [WIDTH-1:0] flip_q
);
  function automatic logic [WIDTH-1:0] apply_mask(logic [WIDTH-1:0] v, logic [WIDTH-1:0] m);
    return v ^ m;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     flip_q <= '0;
    else if (en) flip_q <= apply_mask(flip_q, toggle_mask);
  end
endmodule

// File: rtl/switch_activity_gen.sv
module switch_activity_gen
  import srg_pkg::*;
#(
  parameter int WIDTH = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] walk_o,
  output logic [WIDTH-1:0] ramp_o,
  output logic [WIDTH-1:0] flip_o
);
  localparam int MSB = WIDTH - 1;

  logic       step_up;
  logic       turn_evt;
  logic       at_top;
  logic       at_bottom;
  sweep_dir_e dir_q;

  srg_sweep_ctrl i_ctrl (
    .clk(clk), .rst(rst), .en(en), .at_top(at_top), .at_bottom(at_bottom),
    .step_up(step_up), .turn_evt(turn_evt), .dir_q(dir_q)
  );

  srg_walk_reg #(.WIDTH(WIDTH)) i_walk (
    .clk(clk), .rst(rst), .en(en), .step_up(step_up),
    .walk_q(walk_o), .at_top(at_top), .at_bottom(at_bottom)
  );

  srg_thermo_reg #(.WIDTH(WIDTH)) i_thermo (
    .clk(clk), .rst(rst), .en(en), .step_up(step_up), .ramp_q(ramp_o)
  );

  srg_toggle_reg #(.WIDTH(WIDTH)) i_toggle (
    .clk(clk), .rst(rst), .en(en), .toggle_mask(ramp_o), .flip_q(flip_o)
  );

  // R5
  thermo_tracks_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_o + WIDTH'(1)) == walk_o);
  // R6
  toggle_count_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> $countones(flip_o ^ $past(flip_o)) == $countones($past(ramp_o)));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(walk_o) && $stable(ramp_o) && $stable(flip_o)));
  // R4
  top_bounce_chk: assert property (@(posedge clk) disable iff (rst)
    (en && walk_o[MSB]) |=> walk_o[MSB-1]);
  // R4
  bottom_bounce_chk: assert property (@(posedge clk) disable iff (rst)
    (en && walk_o[0]) |=> walk_o[1]);
  // R4
  turn_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    turn_evt |-> (at_top || at_bottom));
endmodule

// File: tb/test_switch_activity_gen.sv
module test_switch_activity_gen;
  localparam int  W        = 16;
  localparam time CLK_PER  = 10ns;
  localparam int  WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] walk_o, ramp_o, flip_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  int           m_pos  = 0;
  bit           m_up   = 1;
  logic [W-1:0] m_flip = '0;
  int           prev_pos = 0;

  switch_activity_gen #(.WIDTH(W)) i_switch_activity_gen (
    .clk(clk), .rst(rst), .en(en),
    .walk_o(walk_o), .ramp_o(ramp_o), .flip_o(flip_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [W-1:0] ref_ramp(int p);
    logic [W-1:0] r = '0;
    for (int i = 0; i < p; i++) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [W-1:0] ref_walk(int p);
    logic [W-1:0] r = '0;
    r[p] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at edge, compare after edge
  task automatic step(bit r, bit e);
    logic [W-1:0] old_flip;
    @(negedge clk);
    rst = r; en = e;
    old_flip = flip_o;
    @(posedge clk);
    prev_pos = m_pos;
    if (r) begin
      m_pos = 0; m_up = 1; m_flip = '0;
    end else if (e) begin
      m_flip = m_flip ^ ref_ramp(m_pos);
      if (m_up) begin
        if (m_pos == W-1) begin m_up = 0; m_pos--; end else m_pos++;
      end else begin
        if (m_pos == 0) begin m_up = 1; m_pos++; end else m_pos--;
      end
    end
    #1;
    if (r) begin
      check(walk_o == ref_walk(0), "R1 walk", walk_o, ref_walk(0));
      check(ramp_o == '0, "R1 ramp", ramp_o, '0);
      check(flip_o == '0, "R1 flip", flip_o, '0);
    end else begin
      check($onehot(walk_o), "R2 onehot", walk_o, ref_walk(m_pos));
      check(walk_o == ref_walk(m_pos), e ? "R3/R4 position" : "R7 walk hold",
            walk_o, ref_walk(m_pos));
      check(ramp_o == ref_ramp(m_pos), e ? "R5 thermometer" : "R7 ramp hold",
            ramp_o, ref_ramp(m_pos));
      check(flip_o == m_flip, e ? "R6 flip value" : "R7 flip hold", flip_o, m_flip);
      if (e)
        check($countones(flip_o ^ old_flip) == prev_pos, "R6 toggle count",
              W'($countones(flip_o ^ old_flip)), W'(prev_pos));
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    step(1, 0);
    step(1, 1);                       // R1: reset beats enable
    // two full sweeps, continuous enable: exercises R3 R4 R5 R6
    for (int k = 0; k < 4*W; k++) step(0, 1);
    // R4 corner: stop exactly at the top, then verify bounce
    while (m_pos != W-1 || !m_up) step(0, 1);
    check(walk_o[W-1], "R4 at top", walk_o, ref_walk(W-1));
    step(0, 0);                       // R7 pause at the end
    step(0, 1);
    check(walk_o[W-2], "R4 top bounce", walk_o, ref_walk(W-2));
    // pauses sprinkled in: R7 holding including direction
    for (int k = 0; k < 6*W; k++) step(0, (k % 3) != 1);
    // R4 bottom corner
    while (m_pos != 0) step(0, 1);
    step(0, 0);
    step(0, 1);
    check(walk_o[1], "R4 bottom bounce", walk_o, ref_walk(1));
    // R1 mid-sweep reset with enable low then high
    for (int k = 0; k < 5; k++) step(0, 1);
    step(1, 0);
    for (int k = 0; k < 7; k++) step(0, 1);
    step(1, 1);
    for (int k = 0; k < 3*W; k++) step(0, (k % 5) != 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule